// File: doc/BRIEF.md
# Dual-Clock Shift-and-Hold Register

This block turns a serial bit stream into a parallel word, with two register banks that have separate clocks and separate clears. Each rising edge of the shift clock moves every bit one stage deeper and takes the serial input into stage 0. The deepest stage drives a serial output, so the next unit in a chain can take its serial input from it. A rising edge of the capture clock copies the whole shift chain into a holding bank. The holding bank drives the parallel outputs, so those outputs stay stable while new data is shifted in.

Each bank has its own asynchronous active-low clear, and one clear never touches the other bank. The two clocks may run independently. They may also share one net. In that case the holding bank takes the chain contents from before the shared edge, so the parallel word trails the chain by exactly one pulse. The stage count is set by a parameter and defaults to 8.

The data path is a bare serial bit plus clock edges, with no valid/ready handshake. There is no back-pressure: every shift edge takes a bit and every capture edge overwrites the held word.

Top module: `sh_hold_reg`

## Requirements
- R1: On each rising edge of `shift_clk` with `shift_clr_n` high, stage 0 takes `ser_in` and stage n takes the old value of stage n-1.
- R2: `ser_out` always shows the deepest stage (W-1). After a shift edge it equals what stage W-2 held just before that edge.
- R3: On each rising edge of `cap_clk` with `hold_clr_n` high, `par_out[n]` takes the value of shift stage n.
- R4: While `shift_clr_n` is low, every shift stage and `ser_out` are 0. `par_out` keeps its value.
- R5: While `hold_clr_n` is low, `par_out` is 0. The shift stages and `ser_out` keep their values.
- R6: When `shift_clk` and `cap_clk` rise on the same edge, `par_out` takes the chain contents from before that edge, one pulse behind the chain.
- R7: A capture edge that follows a shift clear, with no shift edge in between, loads all zeros into `par_out`.
- R8: A clock edge that arrives while its bank's clear is low has no effect. The first edge after the clear is released works normally.
- R9: Two units chained through `ser_out` act as one chain of 2*W stages. After 2*W shifts, MSB first, and one capture, the downstream unit holds the upper W bits and the upstream unit holds the lower W bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shift_clk | input | 1 | Shift clock, rising edge active |
| shift_clr_n | input | 1 | Asynchronous active-low clear of the shift chain |
| ser_in | input | 1 | Serial data into stage 0 |
| cap_clk | input | 1 | Capture clock, rising edge active |
| hold_clr_n | input | 1 | Asynchronous active-low clear of the holding bank |
| ser_out | output | 1 | Deepest shift stage, used for chaining |
| par_out | output | W | Holding bank contents |

## Verification
The clocked properties compare each bank with its value one edge earlier. They therefore assume a clear is never pulsed low and released entirely between two edges of the clock it governs: whenever a clear is asserted, it stays low across at least one edge of that bank's clock. They also assume `ser_in` and both clears settle away from clock edges. The stimulus keeps to this. It changes data and clears half a period before a rising edge, only while the clocks are low. Every clear it asserts is held through one pulse of the matching clock before it is released.

// File: rtl/sh_hold_pkg.sv
package sh_hold_pkg;
  // default stage count of one unit
  localparam int unsigned SH_DEF_W = 8;
  // value every bank takes while its clear is asserted
  localparam logic SH_CLR_VAL = 1'b0;
endpackage

// File: rtl/sh_bit_flop.sv
module sh_bit_flop
  import sh_hold_pkg::*;
(
  input  logic clk,
  input  logic clr_n,
  input  logic d,
  output logic q
);
  // one storage bit, asynchronous active-low clear
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= SH_CLR_VAL;
    else        q <= d;
  end
endmodule

// File: rtl/sh_stage_chain.sv
module sh_stage_chain #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         sin,
  output logic [W-1:0] q
);
  localparam int unsigned LAST = W - 1;

  logic [W-1:0] nxt;

  // stage 0 takes the serial input; each later stage takes its neighbour
  assign nxt = {q[LAST-1:0], sin};

  for (genvar g = 0; g < W; g++) begin : g_stage
    sh_bit_flop u_bit (
      .clk   (clk),
      .clr_n (clr_n),
      .d     (nxt[g]),
      .q     (q[g])
    );
  end
endmodule

// File: rtl/sh_hold_bank.sv
module sh_hold_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_hold
    sh_bit_flop u_bit (
      .clk   (clk),
      .clr_n (clr_n),
      .d     (d[g]),
      .q     (q[g])
    );
  end
endmodule

// File: rtl/sh_hold_reg.sv
module sh_hold_reg
  import sh_hold_pkg::*;
#(
  parameter int unsigned W = SH_DEF_W
) (
  input  logic         shift_clk,
  input  logic         shift_clr_n,
  input  logic         ser_in,
  input  logic         cap_clk,
  input  logic         hold_clr_n,
  output logic         ser_out,
  output logic [W-1:0] par_out
);
  localparam int unsigned LAST = W - 1;

  logic [W-1:0] stage_q;

  sh_stage_chain #(.W(W)) u_chain (
    .clk   (shift_clk),
    .clr_n (shift_clr_n),
    .sin   (ser_in),
    .q     (stage_q)
  );

  // capture bank samples the chain value present before its own edge
  sh_hold_bank #(.W(W)) u_hold (
    .clk   (cap_clk),
    .clr_n (hold_clr_n),
    .d     (stage_q),
    .q     (par_out)
  );

  assign ser_out = stage_q[LAST];
endmodule

// File: rtl/sh_hold_reg_chk.sv
module sh_hold_reg_chk #(
  parameter int unsigned W = 8
) (
  input logic         shift_clk,
  input logic         shift_clr_n,
  input logic         ser_in,
  input logic         cap_clk,
  input logic         hold_clr_n,
  input logic         ser_out,
  input logic [W-1:0] par_out,
  input logic [W-1:0] stages
);
  // R1
  shift_move_chk: assert property (@(posedge shift_clk) disable iff (!shift_clr_n)
    $past(shift_clr_n) |-> (stages == {$past(stages[W-2:0]), $past(ser_in)}));

  // R2
  ser_tap_chk: assert property (@(posedge shift_clk) disable iff (!shift_clr_n)
    $past(shift_clr_n) |-> (ser_out == $past(stages[W-2])));

  // R3 R6
  capture_copy_chk: assert property (@(posedge cap_clk) disable iff (!hold_clr_n)
    $past(hold_clr_n) |-> (par_out == $past(stages)));

  // R4
  shift_clear_chk: assert property (@(posedge shift_clk) disable iff (hold_clr_n && 1'b0)
    !shift_clr_n |-> (stages == '0 && ser_out == 1'b0));

  // R5
  hold_clear_chk: assert property (@(posedge cap_clk) disable iff (shift_clr_n && 1'b0)
    !hold_clr_n |-> (par_out == '0));
endmodule

bind sh_hold_reg sh_hold_reg_chk #(.W(W)) u_chk (
  .shift_clk   (shift_clk),
  .shift_clr_n (shift_clr_n),
  .ser_in      (ser_in),
  .cap_clk     (cap_clk),
  .hold_clr_n  (hold_clr_n),
  .ser_out     (ser_out),
  .par_out     (par_out),
  .stages      (stage_q)
);

// File: tb/test_sh_hold_reg.sv
module test_sh_hold_reg;
  localparam int unsigned W = 8;
  localparam time CLK_PERIOD = 10;
  localparam time HALF = CLK_PERIOD / 2;
  localparam int unsigned NVEC = 5;
  // {word shifted MSB first, expected downstream par, expected upstream par}
  localparam logic [31:0] VEC [NVEC] = '{
    32'hA55A_A55A, 32'h0001_0001, 32'hFFFF_FFFF, 32'h8000_8000, 32'h3C96_3C96
  };

  logic shift_clk = 0, cap_clk = 0, shift_clr_n = 0, hold_clr_n = 0, ser_in = 0;
  logic link, ser_out_b;
  logic [W-1:0] par_a, par_b;
  logic [15:0] m_sh;
  logic [7:0] m_pa, m_pb;
  int checks = 0, fails = 0;

  sh_hold_reg #(.W(W)) i_sh_hold_reg (
    .shift_clk(shift_clk), .shift_clr_n(shift_clr_n), .ser_in(ser_in),
    .cap_clk(cap_clk), .hold_clr_n(hold_clr_n), .ser_out(link), .par_out(par_a));

  sh_hold_reg #(.W(W)) i_sh_hold_reg_b (
    .shift_clk(shift_clk), .shift_clr_n(shift_clr_n), .ser_in(link),
    .cap_clk(cap_clk), .hold_clr_n(hold_clr_n), .ser_out(ser_out_b), .par_out(par_b));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    ser_in = b; #HALF; shift_clk = 1; #HALF; shift_clk = 0;
    if (shift_clr_n) m_sh = {m_sh[14:0], b};
  endtask

  task automatic capture();
    #HALF; cap_clk = 1; #HALF; cap_clk = 0;
    if (hold_clr_n) begin m_pa = m_sh[7:0]; m_pb = m_sh[15:8]; end
  endtask

  task automatic both(input logic b);
    ser_in = b; #HALF; shift_clk = 1; cap_clk = 1; #HALF; shift_clk = 0; cap_clk = 0;
    m_pa = m_sh[7:0]; m_pb = m_sh[15:8];
    m_sh = {m_sh[14:0], b};
  endtask

  task automatic shift_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) shift_bit(w[i]);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_sh = '0; m_pa = '0; m_pb = '0;
    // reset with both clears low across one pulse of each clock
    shift_bit(1'b1);
    capture();
    check("R8 reset ser_out", {15'd0, ser_out_b}, 16'h0);
    check("R8 reset par", {par_b, par_a}, 16'h0);
    #HALF; shift_clr_n = 1; hold_clr_n = 1;

    // table walk: chained 16-bit transfers
    for (int v = 0; v < NVEC; v++) begin
      shift_word(VEC[v][31:16]);
      check("R2 cascade ser_out", {15'd0, ser_out_b}, {15'd0, VEC[v][31]});
      check("R2 link tap", {15'd0, link}, {15'd0, VEC[v][23]});
      capture();
      check("R3 upstream par", {8'd0, par_a}, {8'd0, VEC[v][7:0]});
      check("R9 downstream par", {8'd0, par_b}, {8'd0, VEC[v][15:8]});
    end

    // R1 single step shift visible after capture
    shift_bit(1'b1);
    capture();
    check("R1 one step", {par_b, par_a}, {m_pb, m_pa});
    check("R1 one step value", {par_b, par_a}, 16'h792D);

    // R6 tied clocks: parallel word lags the chain by one pulse
    shift_word(16'h1234);
    check("R6 before tied edge", {par_b, par_a}, 16'h792D);
    both(1'b1);
    check("R6 tied capture old", {par_b, par_a}, 16'h1234);
    both(1'b0);
    check("R6 tied lag", {par_b, par_a}, 16'h2469);
    capture();
    check("R6 chain state", {par_b, par_a}, 16'h48D2);

    // R5 hold clear: par zero, chain kept, capture during clear ignored
    #HALF; hold_clr_n = 0; #HALF;
    check("R5 par cleared", {par_b, par_a}, 16'h0);
    check("R5 ser_out kept", {15'd0, ser_out_b}, {15'd0, m_sh[15]});
    capture();
    check("R8 capture ignored", {par_b, par_a}, 16'h0);
    #HALF; hold_clr_n = 1;
    capture();
    check("R5 chain kept", {par_b, par_a}, 16'h48D2);

    // R4 shift clear: chain zero, par kept; shift during clear ignored
    shift_word(16'hF0F0);
    capture();
    #HALF; shift_clr_n = 0; #HALF;
    check("R4 ser_out cleared", {15'd0, ser_out_b}, 16'h0);
    check("R4 par kept", {par_b, par_a}, 16'hF0F0);
    shift_bit(1'b1);
    check("R8 shift ignored", {15'd0, ser_out_b}, 16'h0);
    m_sh = '0;
    capture();
    check("R7 zero capture", {par_b, par_a}, 16'h0);
    #HALF; shift_clr_n = 1;
    shift_bit(1'b1);
    capture();
    check("R8 first edge after release", {par_b, par_a}, 16'h0001);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule